// File: doc/BRIEF.md
# ALU with Rotate-Left and Upper-Immediate

A combinational arithmetic-logic unit for the execute stage of a small 32-bit load/store core. It takes two operands, a shift-amount field and the raw `opcode` and `funct` fields of the instruction. A companion decoder turns those fields into an internal operation select. The core then produces the result word and a flag that is set when that result is zero.

The operations are wrapping add, wrapping subtract, AND, OR, signed set-less-than, load-upper-immediate and rotate-left. Address generation for loads and stores uses the add path, and so does add-immediate. The equality branch uses the subtract path, and the branch unit reads the zero flag. Load-upper-immediate is computed in the ALU itself: the low half of the second operand goes to the high half of the result, and the low half of the result is zero. Rotate-left turns the first operand left by the shift-amount field.

The rotator has two variants, chosen by a parameter. One is a single shift-and-merge expression. The other is a logarithmic barrel built with generate. Both give the same function.

Top module: `alu_top`

## Requirements
- R1: With `opcode` 0x00 and `funct` 0x20, or with `opcode` 0x08 (add-immediate), 0x23 (load) or 0x2B (store), `result` is `src_a + src_b` modulo 2^32.
- R2: With `opcode` 0x00 and `funct` 0x22, or with `opcode` 0x04 (equality branch), `result` is `src_a - src_b` modulo 2^32.
- R3: With `opcode` 0x00, `funct` 0x24 gives `src_a & src_b` and `funct` 0x25 gives `src_a | src_b`.
- R4: With `opcode` 0x00 and `funct` 0x2A, `result` bit 0 is 1 exactly when `src_a` is less than `src_b` as signed two's-complement numbers, and bits 31:1 are zero.
- R5: With `opcode` 0x0F, `result[31:16]` equals `src_b[15:0]` and `result[15:0]` is zero.
- R6: With `opcode` 0x00 and `funct` 0x3C, `result` is `src_a` rotated left by `shamt` bit positions, and a `shamt` of 0 returns `src_a` unchanged.
- R7: `zero` is 1 exactly when all 32 bits of `result` are 0. For the equality branch this makes `zero` equal to (`src_a == src_b`).
- R8: A value of `opcode` outside {0x00, 0x04, 0x08, 0x0F, 0x23, 0x2B}, or a `funct` outside {0x20, 0x22, 0x24, 0x25, 0x2A, 0x3C} when `opcode` is 0x00, selects the add operation.
- R9: `shamt` has no effect on `result` or `zero` for any operation other than rotate-left.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opcode | input | 6 | Primary opcode field of the instruction |
| funct | input | 6 | Function field, decoded when `opcode` is 0x00 |
| shamt | input | 5 | Rotate amount for rotate-left |
| src_a | input | 32 | First operand (rs value) |
| src_b | input | 32 | Second operand (rt value or extended immediate) |
| result | output | 32 | Operation result |
| zero | output | 1 | Set when `result` is zero |

## Verification
The bench builds two instances side by side. `dut_i` uses the barrel rotator (`ROT_IMPL` = 1) and a second instance uses the shift-and-merge rotator (`ROT_IMPL` = 0). Both are checked against the same bench model for every vector, so each rotator variant is compared against the model at all 32 rotate amounts. Both instances keep the default 32-bit width, so the signed-compare sign boundaries and the 16-bit upper-immediate split are exercised at their real positions.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_AND = 3'd2,
    OP_OR  = 3'd3,
    OP_SLT = 3'd4,
    OP_LUI = 3'd5,
    OP_ROL = 3'd6
  } alu_op_e;

  localparam logic [5:0] OPC_RTYPE = 6'h00;
  localparam logic [5:0] OPC_BEQ   = 6'h04;
  localparam logic [5:0] OPC_ADDI  = 6'h08;
  localparam logic [5:0] OPC_LUI   = 6'h0F;
  localparam logic [5:0] OPC_LOAD  = 6'h23;
  localparam logic [5:0] OPC_STORE = 6'h2B;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;
  localparam logic [5:0] FN_ROL = 6'h3C;

endpackage

// File: rtl/alu_op_decode.sv
module alu_op_decode
  import alu_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output alu_op_e    op_sel
);

  function automatic alu_op_e decode_rtype(input logic [5:0] fn);
    case (fn)
      FN_SUB:  return OP_SUB;
      FN_AND:  return OP_AND;
      FN_OR:   return OP_OR;
      FN_SLT:  return OP_SLT;
      FN_ROL:  return OP_ROL;
      default: return OP_ADD;
    endcase
  endfunction

  always_comb begin
    case (opcode)
      OPC_RTYPE: op_sel = decode_rtype(funct);
      OPC_BEQ:   op_sel = OP_SUB;
      OPC_LUI:   op_sel = OP_LUI;
      default:   op_sel = OP_ADD;
    endcase
  end

endmodule

// File: rtl/alu_rotl.sv
module alu_rotl #(
  parameter int WIDTH    = 32,
  parameter int ROT_IMPL = 1,
  localparam int SW      = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] din,
  input  logic [SW-1:0]    amt,
  output logic [WIDTH-1:0] dout
);

  generate
    if (ROT_IMPL == 0) begin : g_merge
      localparam logic [SW:0] WV = SW'(0) + (SW+1)'(WIDTH);
      logic [SW:0] back_amt;
      // a right shift by WIDTH (amt == 0) yields zero, leaving din intact
      assign back_amt = WV - {1'b0, amt};
      assign dout = (din << amt) | (din >> back_amt);
    end else begin : g_barrel
      logic [WIDTH-1:0] stage [SW+1];
      assign stage[0] = din;
      for (genvar i = 0; i < SW; i++) begin : g_lvl
        localparam int STEP = 2 ** i;
        assign stage[i+1] = amt[i]
          ? {stage[i][WIDTH-1-STEP:0], stage[i][WIDTH-1:WIDTH-STEP]}
          : stage[i];
      end
      assign dout = stage[SW];
    end
  endgenerate

endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
#(
  parameter int WIDTH    = 32,
  parameter int ROT_IMPL = 1,
  localparam int SW      = $clog2(WIDTH),
  localparam int HALF    = WIDTH / 2
) (
  input  alu_op_e          op_sel,
  input  logic [SW-1:0]    shamt,
  input  logic [WIDTH-1:0] src_a,
  input  logic [WIDTH-1:0] src_b,
  output logic [WIDTH-1:0] result,
  output logic             zero
);

  function automatic logic signed_lt(input logic [WIDTH-1:0] a,
                                     input logic [WIDTH-1:0] b);
    return $signed(a) < $signed(b);
  endfunction

  function automatic logic [WIDTH-1:0] upper_imm(input logic [WIDTH-1:0] b);
    return {b[HALF-1:0], {HALF{1'b0}}};
  endfunction

  logic [WIDTH-1:0] rot_val;

  alu_rotl #(.WIDTH(WIDTH), .ROT_IMPL(ROT_IMPL)) u_rotl (
    .din  (src_a),
    .amt  (shamt),
    .dout (rot_val)
  );

  always_comb begin
    case (op_sel)
      OP_SUB:  result = src_a - src_b;
      OP_AND:  result = src_a & src_b;
      OP_OR:   result = src_a | src_b;
      OP_SLT:  result = {{(WIDTH-1){1'b0}}, signed_lt(src_a, src_b)};
      OP_LUI:  result = upper_imm(src_b);
      OP_ROL:  result = rot_val;
      default: result = src_a + src_b;
    endcase
  end

  assign zero = ~|result;

endmodule

// File: rtl/alu_top.sv
module alu_top
  import alu_pkg::*;
#(
  parameter int WIDTH    = 32,
  parameter int ROT_IMPL = 1,
  localparam int SW      = $clog2(WIDTH)
) (
  input  logic [5:0]       opcode,
  input  logic [5:0]       funct,
  input  logic [SW-1:0]    shamt,
  input  logic [WIDTH-1:0] src_a,
  input  logic [WIDTH-1:0] src_b,
  output logic [WIDTH-1:0] result,
  output logic             zero
);

  alu_op_e op_sel;

  alu_op_decode u_dec (
    .opcode (opcode),
    .funct  (funct),
    .op_sel (op_sel)
  );

  alu_core #(.WIDTH(WIDTH), .ROT_IMPL(ROT_IMPL)) u_core (
    .op_sel (op_sel),
    .shamt  (shamt),
    .src_a  (src_a),
    .src_b  (src_b),
    .result (result),
    .zero   (zero)
  );

endmodule

// File: rtl/alu_top_chk.sv
module alu_top_chk
  import alu_pkg::*;
#(
  parameter int WIDTH = 32,
  localparam int SW   = $clog2(WIDTH),
  localparam int HALF = WIDTH / 2
) (
  input logic [5:0]       opcode,
  input logic [5:0]       funct,
  input logic [SW-1:0]    shamt,
  input logic [WIDTH-1:0] src_a,
  input logic [WIDTH-1:0] src_b,
  input logic [WIDTH-1:0] result,
  input logic             zero,
  input alu_op_e          op_sel
);

  logic is_rtype;
  assign is_rtype = (opcode == OPC_RTYPE);

  always_comb begin
    // R4
    slt_upper_chk: assert (!(is_rtype && funct == FN_SLT) || result[WIDTH-1:1] == '0);
    // R5
    lui_low_chk: assert (!(opcode == OPC_LUI) ||
                         (result[HALF-1:0] == '0 && result[WIDTH-1:HALF] == src_b[HALF-1:0]));
    // R6
    rol_bits_chk: assert (!(is_rtype && funct == FN_ROL) ||
                          $countones(result) == $countones(src_a));
    // R6
    rol_identity_chk: assert (!(is_rtype && funct == FN_ROL && shamt == '0) || result == src_a);
    // R7
    beq_zero_chk: assert (!(opcode == OPC_BEQ) || zero == (src_a == src_b));
    // R7
    zero_flag_chk: assert (zero == (result == '0));
    // R8
    decode_add_chk: assert (!(opcode == OPC_ADDI || opcode == OPC_LOAD || opcode == OPC_STORE) ||
                            op_sel == OP_ADD);
  end

endmodule

bind alu_top alu_top_chk #(.WIDTH(WIDTH)) u_chk (
  .opcode (opcode),
  .funct  (funct),
  .shamt  (shamt),
  .src_a  (src_a),
  .src_b  (src_b),
  .result (result),
  .zero   (zero),
  .op_sel (op_sel)
);

// File: tb/alu_top_tb_top.sv
module alu_top_tb_top;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [5:0]  opcode = '0;
  logic [5:0]  funct  = 6'h20;
  logic [4:0]  shamt  = '0;
  logic [31:0] src_a  = '0;
  logic [31:0] src_b  = '0;
  logic [31:0] res_b, res_m;
  logic        zero_b, zero_m;

  int n_checks = 0;
  int n_fails  = 0;
  int cycles   = 0;
  bit done     = 1'b0;

  alu_top #(.WIDTH(32), .ROT_IMPL(1)) dut_i (
    .opcode (opcode), .funct (funct), .shamt (shamt),
    .src_a (src_a), .src_b (src_b), .result (res_b), .zero (zero_b)
  );

  alu_top #(.WIDTH(32), .ROT_IMPL(0)) dut_m (
    .opcode (opcode), .funct (funct), .shamt (shamt),
    .src_a (src_a), .src_b (src_b), .result (res_m), .zero (zero_m)
  );

  // reference model, written independently of the RTL
  function automatic logic [31:0] ref_rotl(input logic [31:0] a, input int n);
    logic [31:0] v = a;
    for (int k = 0; k < n; k++) v = {v[30:0], v[31]};
    return v;
  endfunction

  function automatic logic ref_less(input logic [31:0] a, input logic [31:0] b);
    if (a[31] != b[31]) return a[31];
    return a < b;
  endfunction

  function automatic logic [31:0] ref_alu(input logic [5:0] opc, input logic [5:0] fn,
                                          input logic [4:0] sh, input logic [31:0] a,
                                          input logic [31:0] b);
    logic [32:0] wide;
    if (opc == 6'h0F) return b << 16;
    if (opc == 6'h04) return a + ~b + 32'd1;
    if (opc == 6'h00) begin
      if (fn == 6'h22) return a + ~b + 32'd1;
      if (fn == 6'h24) return a & b;
      if (fn == 6'h25) return a | b;
      if (fn == 6'h2A) return {31'd0, ref_less(a, b)};
      if (fn == 6'h3C) return ref_rotl(a, int'(sh));
    end
    wide = {1'b0, a} + {1'b0, b};
    return wide[31:0];
  endfunction

  function automatic string req_of(input logic [5:0] opc, input logic [5:0] fn);
    if (opc == 6'h0F) return "R5";
    if (opc == 6'h04) return "R2";
    if (opc == 6'h08 || opc == 6'h23 || opc == 6'h2B) return "R1";
    if (opc != 6'h00) return "R8";
    case (fn)
      6'h20: return "R1";
      6'h22: return "R2";
      6'h24, 6'h25: return "R3";
      6'h2A: return "R4";
      6'h3C: return "R6";
      default: return "R8";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: op=%h fn=%h sh=%0d a=%h b=%h actual=%h expected=%h",
               req, opcode, funct, shamt, src_a, src_b, act, exp);
    end
  endtask

  task automatic apply(input logic [5:0] opc, input logic [5:0] fn, input logic [4:0] sh,
                       input logic [31:0] a, input logic [31:0] b);
    logic [31:0] exp;
    string rq;
    @(negedge clk);
    opcode = opc; funct = fn; shamt = sh; src_a = a; src_b = b;
    #1;
    exp = ref_alu(opc, fn, sh, a, b);
    rq  = req_of(opc, fn);
    check(rq, res_b, exp);
    check(rq, res_m, exp);
    check("R7", {31'd0, zero_b}, {31'd0, exp == 32'd0});
    check("R7", {31'd0, zero_m}, {31'd0, exp == 32'd0});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual=%0d cycles expected=<150000", cycles);
      finish_run();
    end
  end

  localparam logic [5:0] OPCS [6] = '{6'h00, 6'h04, 6'h08, 6'h0F, 6'h23, 6'h2B};
  localparam logic [5:0] FNS  [6] = '{6'h20, 6'h22, 6'h24, 6'h25, 6'h2A, 6'h3C};

  initial begin
    logic [31:0] r_a, r_b, keep;
    void'($urandom(32'd20240611));
    #2;
    // reset-state: default inputs select add of zeros
    check("R1", res_b, 32'd0);
    check("R7", {31'd0, zero_b}, 32'd1);

    // R1 wrap-around and address paths
    apply(6'h00, 6'h20, 5'd0, 32'hFFFF_FFFF, 32'd1);
    apply(6'h08, 6'h3F, 5'd7, 32'h7FFF_FFFF, 32'd1);
    apply(6'h23, 6'h00, 5'd0, 32'h1000_0000, 32'hFFFF_FFFC);
    apply(6'h2B, 6'h00, 5'd0, 32'h0000_0040, 32'h0000_0008);
    // R2 subtract wrap and equality branch
    apply(6'h00, 6'h22, 5'd0, 32'd0, 32'd1);
    apply(6'h04, 6'h00, 5'd0, 32'hDEAD_BEEF, 32'hDEAD_BEEF);
    apply(6'h04, 6'h00, 5'd0, 32'hDEAD_BEEF, 32'hDEAD_BEEE);
    // R3
    apply(6'h00, 6'h24, 5'd0, 32'hF0F0_AAAA, 32'h0FF0_5555);
    apply(6'h00, 6'h25, 5'd0, 32'hF0F0_0000, 32'h0000_0F0F);
    // R4 signed boundaries
    apply(6'h00, 6'h2A, 5'd0, 32'h8000_0000, 32'h7FFF_FFFF);
    apply(6'h00, 6'h2A, 5'd0, 32'h7FFF_FFFF, 32'h8000_0000);
    apply(6'h00, 6'h2A, 5'd0, 32'hFFFF_FFFF, 32'd0);
    apply(6'h00, 6'h2A, 5'd0, 32'd5, 32'd5);
    // R5
    apply(6'h0F, 6'h00, 5'd0, 32'h1234_5678, 32'hABCD_9876);
    apply(6'h0F, 6'h00, 5'd0, 32'd0, 32'hFFFF_0000);
    // R6 every rotate amount, including 0 and 31
    for (int s = 0; s < 32; s++) apply(6'h00, 6'h3C, 5'(s), 32'h8000_0001, 32'd0);
    apply(6'h00, 6'h3C, 5'd0, 32'hCAFE_F00D, 32'h1);
    // R8 unknown opcode and unknown funct
    apply(6'h3E, 6'h22, 5'd0, 32'd10, 32'd3);
    apply(6'h00, 6'h03, 5'd0, 32'd10, 32'd3);

    // R9: shamt changes must not move a non-rotate result
    foreach (FNS[i]) begin
      if (FNS[i] == 6'h3C) continue;
      r_a = $urandom; r_b = $urandom;
      apply(6'h00, FNS[i], 5'd0, r_a, r_b);
      keep = res_b;
      @(negedge clk); shamt = 5'd19; #1;
      check("R9", res_b, keep);
      check("R9", res_m, keep);
    end

    // constrained random mix
    for (int n = 0; n < 3000; n++) begin
      logic [5:0] opc, fn;
      int pick = $urandom_range(0, 15);
      opc = (pick < 10) ? 6'h00 : (pick < 15) ? OPCS[$urandom_range(1, 5)] : 6'($urandom);
      fn  = ($urandom_range(0, 9) == 0) ? 6'($urandom) : FNS[$urandom_range(0, 5)];
      r_a = $urandom;
      r_b = ($urandom_range(0, 7) == 0) ? r_a : $urandom;
      if ($urandom_range(0, 9) == 0) r_a = {$urandom_range(0, 1) == 1, 31'($urandom)} | 32'h8000_0000;
      apply(opc, fn, 5'($urandom), r_a, r_b);
    end

    finish_run();
  end

endmodule